// File: doc/BRIEF.md
# Second-Order Noise-Shaped Digital PWM

This block converts a 13-bit duty command into a pulse-width-modulated drive signal for a switching power converter. A plain counter with the full 13 bits of resolution per switching period would need a counter clock above 1 GHz. Instead, the block splits the command into two parts. The 7 upper bits set a compare value for a 128-slot period counter. The 6 lower bits feed a second-order error-feedback loop. In each period, that loop adds a small signed carry to the compare value. Across many periods the fractional part is dithered into the pulse train, so the long-run duty matches the full 13-bit command. The quantisation error is pushed to high frequency.

A second-order loop is used rather than a first-order accumulator because the first-order version settles into short repeating carry patterns. Those patterns appear as tones on the converter output. The command and the loop state are both taken only at the start of a period, so a pulse is never cut or stretched partway through. A sync input restarts the period at once, which lets several phases or an external timebase line up the switching edges. The compare value is clamped so that every period has at least one high slot and at least one low slot.

Top module: `sd_dpwm`

## Requirements
- R1: While reset is held, `pwmOut` and `periodStrobe` are 0 and the loop error state is cleared. After reset is released, the first period loads on the first clock edge, and `periodStrobe` is first seen high after the second edge.
- R2: Without sync, every period lasts exactly 128 clock cycles. `periodStrobe` is high for exactly the first cycle of each period.
- R3: Each period, `pwmOut` is high for the first C cycles and low for the rest, as one contiguous pulse. C is the upper 7 command bits plus the loop carry, clamped to the range 1..127.
- R4: The loop carry follows a fixed rule. The loop computes u = L + 2·e1 − e2, where L is the lower 6 command bits and e1, e2 are the two previous error values. The carry is q = floor((u+32)/64), and the new error is u − 64·q. The error state advances only at period start, and it starts from zero after reset. For example, with L = 16 the carry sequence from reset is 0,1,0,0,0,0,1,0 and then repeats.
- R5: A change of `dutyCmd` during a period has no effect on that period. The new value is used from the next period start.
- R6: Hold the command constant from reset, with upper bits in 2..125, and sum the high cycles H over N whole periods. Then |64·H − N·command| ≤ 63.
- R7: No period is fully low or fully high. A command of 0 gives 1 high cycle per period, and a command of 8191 gives 127.
- R8: A high level on `syncIn` at a clock edge starts a new period at that edge and loads the present command. `periodStrobe` is then seen high after the following edge, and a full 128-cycle period follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and loop clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dutyCmd | input | 13 | Duty command, unsigned; 8192 is a full period |
| syncIn | input | 1 | Restart the period at this edge |
| pwmOut | output | 1 | Registered PWM drive |
| periodStrobe | output | 1 | High in the first cycle of each period |

## Verification
The hardest behaviour to reach from the ports is the exact carry sequence of the second-order loop. Only the high-cycle count of each period shows it, and once a few periods have run it depends on the whole history. The bench therefore resets before each loop test and holds a command whose lower bits are 16. The per-period count is then a known 8-period pattern that a first-order loop would break by its sixth period. Long runs check the averaging bound, and mid-period command changes and sync pulses are placed at counted cycles after a strobe.

// File: rtl/sd_dpwm_pkg.sv
package sd_dpwm_pkg;
  // Strobes from the period control to the datapath
  typedef struct packed {
    logic load;       // this edge starts a new period
    logic firstSlot;  // counter sits on slot 0
    logic lastSlot;   // counter sits on the final slot
  } ctlStrobe_t;
endpackage

// File: rtl/sd_dpwm_ctrl.sv
module sd_dpwm_ctrl
  import sd_dpwm_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncIn,
  output logic [CNT_W-1:0] slotCnt,
  output ctlStrobe_t       strobes
);
  localparam logic [CNT_W-1:0] LAST_SLOT = '1;

  logic [CNT_W-1:0] cntQ;

  always_comb begin
    strobes.lastSlot  = (cntQ == LAST_SLOT);
    strobes.firstSlot = (cntQ == '0);
    strobes.load      = syncIn || strobes.lastSlot;
  end

  // Reset to the last slot so the first edge after reset loads a period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cntQ <= LAST_SLOT;
    else if (strobes.load) cntQ <= '0;
    else                   cntQ <= cntQ + 1'b1;
  end

  assign slotCnt = cntQ;

  // R2: free-running step between period starts
  assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!syncIn && cntQ != LAST_SLOT) |=> cntQ == CNT_W'($past(cntQ) + 1'b1));

  // R2: wrap after the final slot
  assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lastSlot |=> strobes.firstSlot);

  // R8: sync restarts the period
  assert_sync_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    syncIn |=> cntQ == '0);
endmodule

// File: rtl/sd_dpwm_shaper.sv
module sd_dpwm_shaper #(
  parameter int FRAC_W = 6,
  parameter int CARRY_W = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      advance,
  input  logic [FRAC_W-1:0]         frac,
  output logic signed [CARRY_W-1:0] carry
);
  localparam int SUM_W = FRAC_W + CARRY_W;
  localparam logic signed [SUM_W-1:0] HALF =
    {{(SUM_W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic signed [FRAC_W-1:0] err1Q, err2Q, errNext;
  logic signed [SUM_W-1:0]  fracExt, e1Ext, e2Ext, sumU, biased;

  always_comb begin
    fracExt = {{(SUM_W-FRAC_W){1'b0}}, frac};
    e1Ext   = {{(SUM_W-FRAC_W){err1Q[FRAC_W-1]}}, err1Q};
    e2Ext   = {{(SUM_W-FRAC_W){err2Q[FRAC_W-1]}}, err2Q};
    // double-zero noise transfer: u = x + 2e[n-1] - e[n-2]
    sumU    = fracExt + (e1Ext <<< 1) - e2Ext;
    biased  = sumU + HALF;
    // rounding quantiser: upper part is the carry, lower part re-centred is the error
    carry   = biased[SUM_W-1:FRAC_W];
    errNext = {~biased[FRAC_W-1], biased[FRAC_W-2:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      err1Q <= '0;
      err2Q <= '0;
    end else if (advance) begin
      err2Q <= err1Q;
      err1Q <= errNext;
    end
  end

  // R4: state only moves at period start
  assert_state_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !advance |=> ($stable(err1Q) && $stable(err2Q)));

  // R4: second tap is the delayed first tap
  assert_state_shift_R4: assert property (@(posedge clk) disable iff (!rstN)
    advance |=> err2Q == $past(err1Q));
endmodule

// File: rtl/sd_dpwm_dpath.sv
module sd_dpwm_dpath
  import sd_dpwm_pkg::*;
#(
  parameter int CMD_W = 13,
  parameter int FRAC_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CMD_W-1:0] dutyCmd,
  input  logic [CMD_W-FRAC_W-1:0] slotCnt,
  input  ctlStrobe_t       strobes,
  output logic             pwmOut,
  output logic             periodStrobe
);
  localparam int CNT_W   = CMD_W - FRAC_W;
  localparam int CARRY_W = 4;
  localparam int SUM_W   = CNT_W + CARRY_W;
  localparam logic signed [SUM_W-1:0] CMP_MIN = SUM_W'(1);
  localparam logic signed [SUM_W-1:0] CMP_MAX =
    {{(SUM_W-CNT_W){1'b0}}, {CNT_W{1'b1}}};

  logic [CNT_W-1:0]          coarse;
  logic [FRAC_W-1:0]         frac;
  logic signed [CARRY_W-1:0] carry;
  logic signed [SUM_W-1:0]   rawCmp;
  logic [CNT_W-1:0]          cmpNext, cmpQ;
  logic                      pwmQ, strobeQ;

  assign coarse = dutyCmd[CMD_W-1:FRAC_W];
  assign frac   = dutyCmd[FRAC_W-1:0];

  sd_dpwm_shaper #(.FRAC_W(FRAC_W), .CARRY_W(CARRY_W)) u_shaper (
    .clk     (clk),
    .rstN    (rstN),
    .advance (strobes.load),
    .frac    (frac),
    .carry   (carry)
  );

  always_comb begin
    rawCmp = $signed({{(SUM_W-CNT_W){1'b0}}, coarse})
           + $signed({{(SUM_W-CARRY_W){carry[CARRY_W-1]}}, carry});
    if (rawCmp < CMP_MIN)      cmpNext = CMP_MIN[CNT_W-1:0];
    else if (rawCmp > CMP_MAX) cmpNext = CMP_MAX[CNT_W-1:0];
    else                       cmpNext = rawCmp[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpQ    <= CMP_MIN[CNT_W-1:0];
      pwmQ    <= 1'b0;
      strobeQ <= 1'b0;
    end else begin
      if (strobes.load) cmpQ <= cmpNext;
      pwmQ    <= (slotCnt < cmpQ);
      strobeQ <= strobes.firstSlot;
    end
  end

  assign pwmOut       = pwmQ;
  assign periodStrobe = strobeQ;

  // R5: compare value frozen inside a period
  assert_cmp_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(cmpQ));

  // R7: compare never zero
  assert_cmp_nonzero_R7: assert property (@(posedge clk) disable iff (!rstN)
    cmpQ != '0);

  // R7: first slot always drives high
  assert_first_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.firstSlot |=> pwmOut);

  // R7: final slot always drives low
  assert_last_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lastSlot |=> !pwmOut);
endmodule

// File: rtl/sd_dpwm.sv
module sd_dpwm
  import sd_dpwm_pkg::*;
#(
  parameter int CMD_W = 13,
  parameter int FRAC_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CMD_W-1:0] dutyCmd,
  input  logic             syncIn,
  output logic             pwmOut,
  output logic             periodStrobe
);
  localparam int CNT_W = CMD_W - FRAC_W;

  logic [CNT_W-1:0] slotCnt;
  ctlStrobe_t       strobes;

  sd_dpwm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .syncIn  (syncIn),
    .slotCnt (slotCnt),
    .strobes (strobes)
  );

  sd_dpwm_dpath #(.CMD_W(CMD_W), .FRAC_W(FRAC_W)) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .dutyCmd      (dutyCmd),
    .slotCnt      (slotCnt),
    .strobes      (strobes),
    .pwmOut       (pwmOut),
    .periodStrobe (periodStrobe)
  );
endmodule

// File: tb/sd_dpwm_tb.sv
module sd_dpwm_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] dutyCmd = '0;
  logic        syncIn = 1'b0;
  logic        pwmOut, periodStrobe;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;  // 250 MHz

  sd_dpwm u_dut (
    .clk(clk), .rstN(rstN), .dutyCmd(dutyCmd), .syncIn(syncIn),
    .pwmOut(pwmOut), .periodStrobe(periodStrobe)
  );

  // first-period table: command, expected high cycles (upper bits + round(lower/64), clamped 1..127)
  localparam int NVEC = 9;
  localparam logic [12:0] VEC_CMD [NVEC] =
    '{13'd0, 13'd8191, 13'd2560, 13'd2591, 13'd2592, 13'd6463, 13'd64, 13'd8104, 13'd330};
  localparam int VEC_HIGH [NVEC] = '{1, 127, 40, 40, 41, 101, 1, 127, 5};
  localparam int AVG_N = 48;
  localparam logic [12:0] AVG_CMD [4] = '{13'd3221, 13'd1281, 13'd7102, 13'd242};
  localparam int Q16 [8] = '{0, 1, 0, 0, 0, 0, 1, 0};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitStrobe();
    int guard = 0;
    while (!periodStrobe && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // R1 reset checks; ends on the negedge showing the first strobe
  task automatic applyReset(input logic [12:0] cmd);
    rstN = 1'b0;
    syncIn = 1'b0;
    dutyCmd = cmd;
    repeat (3) @(negedge clk);
    check(pwmOut == 1'b0 && periodStrobe == 1'b0, "R1 outputs low in reset",
          {pwmOut, periodStrobe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(periodStrobe == 1'b0, "R1 no strobe after first edge", periodStrobe, 0);
    @(negedge clk);
    check(periodStrobe == 1'b1, "R1 strobe after second edge", periodStrobe, 1);
  endtask

  // starts on a strobe negedge, ends on the next one
  task automatic measurePeriod(input int changeAt, input logic [12:0] newCmd,
                               output int highCnt, output int len, output bit contiguous);
    bit seenLow;
    seenLow = 1'b0;
    highCnt = 0;
    len = 0;
    contiguous = 1'b1;
    do begin
      if (pwmOut) begin
        highCnt++;
        if (seenLow) contiguous = 1'b0;
      end else begin
        seenLow = 1'b1;
      end
      len++;
      if (len == changeAt) dutyCmd = newCmd;
      @(negedge clk);
    end while (!periodStrobe && len < 1000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int hi, len, sumHigh, diff;
    bit contig, lenOk, rangeOk;

    // R3 / R7: first period after reset, table-driven
    for (int i = 0; i < NVEC; i++) begin
      applyReset(VEC_CMD[i]);
      measurePeriod(-1, '0, hi, len, contig);
      check(hi == VEC_HIGH[i], "R3 first-period high count", hi, VEC_HIGH[i]);
      check(contig, "R3 single contiguous pulse", contig, 1);
      check(len == 128, "R2 period length", len, 128);
    end

    // R7: extremes held over many periods
    applyReset(13'd0);
    rangeOk = 1'b1;
    for (int p = 0; p < 8; p++) begin
      measurePeriod(-1, '0, hi, len, contig);
      if (hi != 1 || len != 128) rangeOk = 1'b0;
    end
    check(rangeOk, "R7 zero command keeps one high cycle", hi, 1);
    applyReset(13'd8191);
    rangeOk = 1'b1;
    for (int p = 0; p < 8; p++) begin
      measurePeriod(-1, '0, hi, len, contig);
      if (hi != 127 || len != 128) rangeOk = 1'b0;
    end
    check(rangeOk, "R7 full command keeps one low cycle", hi, 127);

    // R4: lower bits 16 give carry pattern 0,1,0,0,0,0,1,0
    applyReset(13'd1936);  // 30*64 + 16
    for (int p = 0; p < 16; p++) begin
      measurePeriod(-1, '0, hi, len, contig);
      check(hi == 30 + Q16[p % 8], "R4 second-order carry sequence", hi, 30 + Q16[p % 8]);
    end

    // R6: long-run average within one period-slot
    for (int c = 0; c < 4; c++) begin
      applyReset(AVG_CMD[c]);
      sumHigh = 0;
      lenOk = 1'b1;
      for (int p = 0; p < AVG_N; p++) begin
        measurePeriod(-1, '0, hi, len, contig);
        sumHigh += hi;
        if (len != 128) lenOk = 1'b0;
      end
      diff = 64 * sumHigh - AVG_N * int'(AVG_CMD[c]);
      if (diff < 0) diff = -diff;
      check(diff <= 63, "R6 average duty error", diff, 63);
      check(lenOk, "R2 period length over run", lenOk, 1);
    end

    // R5: mid-period command change waits for the next period
    applyReset(13'd2560);
    measurePeriod(10, 13'd5760, hi, len, contig);
    check(hi == 40, "R5 change ignored in current period", hi, 40);
    measurePeriod(-1, '0, hi, len, contig);
    check(hi == 90, "R5 change applied next period", hi, 90);

    // R8: sync restarts the period and loads the command
    applyReset(13'd2560);
    repeat (20) @(negedge clk);
    dutyCmd = 13'd4480;  // 70*64
    syncIn = 1'b1;
    @(negedge clk);
    syncIn = 1'b0;
    check(periodStrobe == 1'b0, "R8 no strobe on sync edge", periodStrobe, 0);
    @(negedge clk);
    check(periodStrobe == 1'b1, "R8 strobe one edge after sync", periodStrobe, 1);
    measurePeriod(-1, '0, hi, len, contig);
    check(hi == 70, "R8 sync loads new command", hi, 70);
    check(len == 128, "R8 full period after sync", len, 128);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule